// File: doc/BRIEF.md
# Clock Loss Detector

The block watches a monitored system clock from a free-running reference clock and asks the reset controller for a system reset when the monitored clock stops toggling. It behaves like a retriggerable one-shot. The monitored clock is sampled as data in the reference domain. Every change of its synchronized level restarts a window timer. If the clock stays stuck high or stuck low for longer than the window, a one-cycle reset request is produced. After a request, the block waits for the resulting system reset. It issues nothing more until that reset has come and gone.

Software sees a single bit. Writing it enables or disables the detector. Reading it returns the cause flag, which says whether the most recent system reset was caused by this detector. The request drives only the reset controller and never an external reset pin.

The control is a five-state machine:
- `ST_OFF`: the detector is disabled.
- `ST_WATCH`: the window timer is running.
- `ST_FIRE`: the single request cycle.
- `ST_HOLD`: the request has been issued and the block waits for the system reset.
- `ST_INRST`: the system reset is being held.

Transitions:
- OFF to WATCH on a write of 1.
- WATCH to OFF on a write of 0.
- WATCH to FIRE when the window expires.
- FIRE to HOLD unconditionally.
- Any state to INRST while `sys_rst` is high.
- INRST to OFF when `sys_rst` falls.

Top module: `clk_loss_detector`

## Requirements
- R1: With the detector enabled, a monitored clock whose level changes at intervals of at most WINDOW reference cycles never produces a request.
- R2: When the monitored clock changes to low and stays low, `rst_req` rises exactly WINDOW+3 reference rising edges after the change. This counts two synchronizer stages and one previous-value stage before the timer.
- R3: When the monitored clock changes to high and stays high, the request appears with the same WINDOW+3 latency as in R2.
- R4: A gap of exactly WINDOW reference cycles between level changes produces no request. A gap of WINDOW+1 cycles produces one.
- R5: `rst_req` is high for exactly one reference cycle. After it, no further request is issued until `sys_rst` has been asserted and released. Enable writes made in that interval are ignored.
- R6: A write with `en_wr`=1 and `en_wdata`=1 enables the detector, and a write with `en_wdata`=0 disables it. While the detector is disabled, no request is made whatever the monitored clock does. With a static clock, an enable write produces a request WINDOW+1 rising edges after the write cycle.
- R7: `cause_flag` is 0 after power-on reset. It reads 1 after a system reset that follows a request from this block, and 0 after a system reset from any other source. It changes only while `sys_rst` is high.
- R8: While `sys_rst` is high, no request is made. Any system reset leaves the detector disabled until it is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst | input | 1 | High while the reset controller holds the system in reset |
| mon_clk | input | 1 | Monitored system clock, sampled as data |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Enable value written: 1 enables, 0 disables |
| cause_flag | output | 1 | Reads 1 if the last system reset came from this detector |
| rst_req | output | 1 | One-cycle reset request to the reset controller |

## Verification
The bench targets the window boundary with gaps of exactly WINDOW and WINDOW+1 cycles. A timer compared off by one would either fire on a legitimate slow clock or tolerate a stopped one for an extra cycle. The exact request latency is checked for both stuck levels, so a synchronizer with a missing stage or an edge detector that reacts to only one direction is caught. The bench also checks that the request lasts one cycle, does not repeat and ignores writes while the reset is pending; a design that re-armed early would flood the reset controller. The cause flag is checked after a detector reset and after a foreign reset, and the detector is checked to stay disabled after each one. A flag that latched the wrong cause or did not clear would misreport the reset source.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_WATCH = 3'd1,
        ST_FIRE  = 3'd2,
        ST_HOLD  = 3'd3,
        ST_INRST = 3'd4
    } mcd_state_e;

endpackage

// File: rtl/mcd_sync.sv
// Brings the monitored clock into the reference domain as data and
// flags every change of its synchronized level.
module mcd_sync #(
    parameter int STAGES = 2
) (
    input  logic ref_clk,
    input  logic por_n,
    input  logic din,
    output logic level_chg
);
    // sr[STAGES-1] is the synchronized level; sr[STAGES] is its previous value
    logic [STAGES:0] sr;

    always_ff @(posedge ref_clk or negedge por_n) begin
        if (!por_n) begin
            sr <= '0;
        end else begin
            sr <= {sr[STAGES-1:0], din};
        end
    end

    assign level_chg = sr[STAGES] ^ sr[STAGES-1];

endmodule

// File: rtl/mcd_window_timer.sv
// Counts reference cycles without a level change while running.
// The count clears on a change and holds at the terminal value.
module mcd_window_timer #(
    parameter int WINDOW = 8
) (
    input  logic ref_clk,
    input  logic por_n,
    input  logic run,
    input  logic level_chg,
    output logic expired
);
    localparam int CNT_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired = run && !level_chg && (cnt_q == LAST);

    always_ff @(posedge ref_clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (!run || level_chg) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mcd_ctrl_fsm.sv
// Enable, request and cause-flag control for the detector.
module mcd_ctrl_fsm
    import mcd_pkg::*;
(
    input  logic       ref_clk,
    input  logic       por_n,
    input  logic       sys_rst,
    input  logic       en_wr,
    input  logic       en_wdata,
    input  logic       expired,
    output logic       run,
    output logic       rst_req,
    output logic       cause_flag,
    output mcd_state_e state
);
    mcd_state_e state_q, state_d;
    logic       flag_q;

    // next state
    always_comb begin
        state_d = state_q;
        if (sys_rst) begin
            state_d = ST_INRST;
        end else begin
            unique case (state_q)
                ST_OFF:   if (en_wr && en_wdata)  state_d = ST_WATCH;
                ST_WATCH: if (en_wr && !en_wdata) state_d = ST_OFF;
                          else if (expired)       state_d = ST_FIRE;
                ST_FIRE:  state_d = ST_HOLD;
                ST_HOLD:  state_d = ST_HOLD;
                ST_INRST: state_d = ST_OFF;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge ref_clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // cause flag: captured when a system reset begins
    always_ff @(posedge ref_clk or negedge por_n) begin
        if (!por_n) begin
            flag_q <= 1'b0;
        end else if (sys_rst && state_q != ST_INRST) begin
            flag_q <= (state_q == ST_FIRE) || (state_q == ST_HOLD);
        end
    end

    // outputs
    always_comb begin
        run        = (state_q == ST_WATCH);
        rst_req    = (state_q == ST_FIRE);
        cause_flag = flag_q;
        state      = state_q;
    end

endmodule

// File: rtl/clk_loss_detector.sv
module clk_loss_detector #(
    parameter int WINDOW      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic por_n,
    input  logic sys_rst,
    input  logic mon_clk,
    input  logic en_wr,
    input  logic en_wdata,
    output logic cause_flag,
    output logic rst_req
);
    logic               mon_chg;
    logic               timer_run;
    logic               timer_expired;
    mcd_pkg::mcd_state_e fsm_state;

    mcd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .ref_clk   (ref_clk),
        .por_n     (por_n),
        .din       (mon_clk),
        .level_chg (mon_chg)
    );

    mcd_window_timer #(.WINDOW(WINDOW)) u_timer (
        .ref_clk   (ref_clk),
        .por_n     (por_n),
        .run       (timer_run),
        .level_chg (mon_chg),
        .expired   (timer_expired)
    );

    mcd_ctrl_fsm u_fsm (
        .ref_clk    (ref_clk),
        .por_n      (por_n),
        .sys_rst    (sys_rst),
        .en_wr      (en_wr),
        .en_wdata   (en_wdata),
        .expired    (timer_expired),
        .run        (timer_run),
        .rst_req    (rst_req),
        .cause_flag (cause_flag),
        .state      (fsm_state)
    );

endmodule

// File: rtl/clk_loss_detector_checker.sv
module clk_loss_detector_checker
    import mcd_pkg::*;
#(
    parameter int WINDOW = 8
) (
    input logic       ref_clk,
    input logic       por_n,
    input logic       sys_rst,
    input logic       rst_req,
    input logic       cause_flag,
    input logic       mon_chg,
    input mcd_state_e fsm_state
);
    localparam int QW = $clog2(WINDOW + 2) + 1;

    // independent count of reference cycles since the last level change
    logic [QW-1:0] quiet;
    always_ff @(posedge ref_clk or negedge por_n) begin
        if (!por_n) begin
            quiet <= '0;
        end else if (mon_chg) begin
            quiet <= '0;
        end else if (quiet != {QW{1'b1}}) begin
            quiet <= quiet + 1'b1;
        end
    end

    a_r5_single_pulse: assert property (@(posedge ref_clk) disable iff (!por_n)
        rst_req |=> !rst_req);

    // covers both stuck levels (R2, R3) and the boundary (R4)
    a_r2_quiet_before_req: assert property (@(posedge ref_clk) disable iff (!por_n)
        rst_req |-> (quiet >= QW'(WINDOW)));

    a_r6_req_only_from_watch: assert property (@(posedge ref_clk) disable iff (!por_n)
        rst_req |-> ($past(fsm_state) == ST_WATCH));

    a_r8_no_req_in_reset: assert property (@(posedge ref_clk) disable iff (!por_n)
        $past(sys_rst) |-> !rst_req);

    a_r7_flag_stable: assert property (@(posedge ref_clk) disable iff (!por_n)
        !$past(sys_rst) |-> $stable(cause_flag));

endmodule

bind clk_loss_detector clk_loss_detector_checker #(.WINDOW(WINDOW)) u_chk (
    .ref_clk    (ref_clk),
    .por_n      (por_n),
    .sys_rst    (sys_rst),
    .rst_req    (rst_req),
    .cause_flag (cause_flag),
    .mon_chg    (mon_chg),
    .fsm_state  (fsm_state)
);

// File: tb/clk_loss_detector_bench.sv
module clk_loss_detector_bench;
    localparam int W = 8;

    logic clk = 1'b0;
    logic por_n, sys_rst, mon_clk, en_wr, en_wdata;
    logic cause_flag, rst_req;
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    always #2.5 clk = ~clk;

    clk_loss_detector #(.WINDOW(W), .SYNC_STAGES(2)) u_clk_loss_detector (
        .ref_clk    (clk),
        .por_n      (por_n),
        .sys_rst    (sys_rst),
        .mon_clk    (mon_clk),
        .en_wr      (en_wr),
        .en_wdata   (en_wdata),
        .cause_flag (cause_flag),
        .rst_req    (rst_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // step n cycles and count cycles with the request high
    task automatic step_watch(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_req) hits++;
        end
    endtask

    task automatic write_en(input bit v);
        en_wr = 1'b1; en_wdata = v;
        step(1);
        en_wr = 1'b0; en_wdata = 1'b0;
    endtask

    task automatic pulse_sys_rst(input int n);
        sys_rst = 1'b1;
        step(n);
        sys_rst = 1'b0;
        step(1);
    endtask

    // change to level and expect the request exactly W+3 edges later
    task automatic stuck_at(input bit level, input string tag);
        mon_clk = level;
        step(W + 2);
        chk(rst_req == 1'b0, tag, rst_req, 0);
        step(1);
        chk(rst_req == 1'b1, tag, rst_req, 1);
        step(1);
        chk(rst_req == 1'b0, "R5 pulse width", rst_req, 0);
    endtask

    task automatic t_reset_state();
        int hits;
        chk(cause_flag == 1'b0, "R7 flag after power-on", cause_flag, 0);
        chk(rst_req == 1'b0, "R6 no req at power-on", rst_req, 0);
        step_watch(3 * W, hits);
        chk(hits == 0, "R6 disabled by default", hits, 0);
    endtask

    task automatic t_toggling_ok();
        int hits, tot;
        write_en(1'b1);
        tot = 0;
        for (int k = 0; k < 20; k++) begin
            mon_clk = ~mon_clk;
            step_watch(3, hits);
            tot += hits;
        end
        chk(tot == 0, "R1 running clock", tot, 0);
    endtask

    task automatic t_stuck_low();
        int hits;
        if (mon_clk == 1'b0) begin mon_clk = 1'b1; step(3); end
        stuck_at(1'b0, "R2 stuck low latency");
        step_watch(20, hits);
        chk(hits == 0, "R5 no repeat", hits, 0);
        write_en(1'b1);
        step_watch(3 * W, hits);
        chk(hits == 0, "R5 write ignored while pending", hits, 0);
        chk(cause_flag == 1'b0, "R7 flag unchanged before reset", cause_flag, 0);
        pulse_sys_rst(4);
        chk(cause_flag == 1'b1, "R7 flag after detector reset", cause_flag, 1);
        step_watch(3 * W, hits);
        chk(hits == 0, "R8 disabled after reset", hits, 0);
    endtask

    task automatic t_stuck_high();
        write_en(1'b1);
        mon_clk = 1'b0;
        step(3);
        stuck_at(1'b1, "R3 stuck high latency");
        pulse_sys_rst(3);
        chk(cause_flag == 1'b1, "R7 flag after second detector reset", cause_flag, 1);
    endtask

    task automatic t_boundary();
        int hits, tot;
        write_en(1'b1);
        tot = 0;
        for (int k = 0; k < 6; k++) begin
            mon_clk = ~mon_clk;
            step_watch(W, hits);
            tot += hits;
        end
        chk(tot == 0, "R4 gap of WINDOW", tot, 0);
        mon_clk = ~mon_clk;
        step_watch(W + 1, hits);
        mon_clk = ~mon_clk;
        step(1);
        chk(rst_req == 1'b0 && hits == 0, "R4 before expiry", hits, 0);
        step(1);
        chk(rst_req == 1'b1, "R4 gap of WINDOW+1", rst_req, 1);
        pulse_sys_rst(3);
    endtask

    task automatic t_enable_disable();
        int hits;
        write_en(1'b1);
        write_en(1'b0);
        step_watch(3 * W, hits);
        chk(hits == 0, "R6 disabled ignores stopped clock", hits, 0);
        en_wr = 1'b1; en_wdata = 1'b1;
        step(1);
        en_wr = 1'b0; en_wdata = 1'b0;
        step(W - 1);
        chk(rst_req == 1'b0, "R6 enable latency early", rst_req, 0);
        step(1);
        chk(rst_req == 1'b1, "R6 enable latency", rst_req, 1);
        pulse_sys_rst(3);
        chk(cause_flag == 1'b1, "R7 flag after enable timeout", cause_flag, 1);
    endtask

    task automatic t_other_reset();
        int hits;
        write_en(1'b1);
        for (int k = 0; k < 4; k++) begin mon_clk = ~mon_clk; step(2); end
        pulse_sys_rst(3);
        chk(cause_flag == 1'b0, "R7 flag after foreign reset", cause_flag, 0);
        step_watch(3 * W, hits);
        chk(hits == 0, "R8 disabled after foreign reset", hits, 0);
        write_en(1'b1);
        sys_rst = 1'b1;
        step_watch(3 * W, hits);
        chk(hits == 0, "R8 no req during reset", hits, 0);
        sys_rst = 1'b0;
        step(1);
        chk(cause_flag == 1'b0, "R7 flag after long foreign reset", cause_flag, 0);
    endtask

    initial begin
        por_n = 1'b0; sys_rst = 1'b0; mon_clk = 1'b0; en_wr = 1'b0; en_wdata = 1'b0;
        step(5);
        por_n = 1'b1;
        step(1);
        t_reset_state();
        t_toggling_ok();
        t_stuck_low();
        t_stuck_high();
        t_boundary();
        t_enable_disable();
        t_other_reset();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule